// File: doc/BRIEF.md
# Serial Transmitter with Sync Break

This block turns bytes from a host into an asynchronous serial stream on one output line. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. There is no parity. Each bit lasts sixteen pulses of an external baud tick. A four-entry first-in-first-out buffer sits in front of the shift register, so the host can queue several characters ahead of the line. The host gets three signals back: a buffer-full flag, a shift-empty flag and a one-cycle interrupt pulse. A 2-bit mode input selects which event raises the interrupt.

A sync break is requested with a one-cycle pulse on `brk_set`. That pulse sets a pending flag. At the next frame boundary the transmitter sends a break frame: a start bit, twelve low bits and a stop bit. No buffered character is consumed. The flag clears itself when the break frame ends. Dropping `tx_en` has three effects:
- any frame in progress is cut off;
- the buffer and any pending break are cleared;
- the output line is handed over to a static port value.

The idle level of the line comes from a polarity bit. The meaning of that bit depends on whether an external pulse encoder is enabled. The whole frame is inverted along with the idle level.

The frame state machine has five named states:
- `ST_IDLE` (line at idle level);
- `ST_START`;
- `ST_DATA`;
- `ST_BREAK`;
- `ST_STOP`.

Its transitions are:
- **load**: `ST_IDLE`→`ST_START` when a break is pending or the buffer holds data. A pending break wins, and a data load pops the buffer.
- **start_done**: `ST_START`→`ST_DATA` for a data frame, or `ST_START`→`ST_BREAK` for a break frame. This happens after 16 ticks.
- **data_done**: `ST_DATA`→`ST_STOP` after the eighth data bit.
- **break_done**: `ST_BREAK`→`ST_STOP` after the twelfth low bit.
- **stop_done**: `ST_STOP`→`ST_IDLE` after 16 ticks.
- **abort**: any state →`ST_IDLE` when `tx_en` is low.

Top module: `uart_tx_brk`

## Requirements
- R1: The buffer holds up to 4 characters and sends them in write order. `buf_full` is high exactly when 4 are held. A write (`wr_en` high) while `buf_full` is high is dropped and changes nothing.
- R2: A data frame is a low start bit, then 8 data bits with bit 0 first, then a high stop bit. Each bit is held for 16 `baud_tick` pulses. A character is moved from the buffer into the shift register in the clock cycle after the line goes idle with data queued.
- R3: `sh_empty` is high exactly when no frame is in progress, the buffer is empty and no break is pending. It changes in the cycle right after the clock edge of the event that causes it.
- R4: With `irq_mode` = 00, `irq` pulses high for one cycle right after each move of a character from the buffer into the shift register.
- R5: With `irq_mode` = 10, `irq` pulses only after such a move that leaves the buffer empty. A write in the same cycle counts toward the buffer level.
- R6: With `irq_mode` = 01, `irq` pulses right after a stop bit ends, but only if at that point the buffer is empty and no break is pending.
- R7: With `irq_mode` = 11, `irq` never goes high.
- R8: A pulse on `brk_set` while enabled sets `brk_flag`. At the next frame boundary a pending break is sent before any queued data. The break frame is a start bit, twelve low bits and a high stop bit, 16 ticks each. `brk_flag` clears in the cycle after the break's stop bit ends. The break consumes no character.
- R9: While `tx_en` is low, `tx_out` equals `port_val`. Writes and break requests are ignored. One cycle after `tx_en` falls, the frame is aborted, the buffer is empty and no break is pending.
- R10: The idle level is `inv_sel` when `enc_on` = 1, and `!inv_sel` when `enc_on` = 0. Every frame bit is driven as its nominal level XOR (NOT idle level).
- R11: After reset, `tx_out` sits at the idle level, `sh_empty` is high, and `buf_full`, `brk_flag` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable; low aborts and clears |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| brk_set | input | 1 | One-cycle request for a sync break |
| inv_sel | input | 1 | Idle polarity select |
| enc_on | input | 1 | External pulse encoder enabled (swaps meaning of inv_sel) |
| irq_mode | input | 2 | Interrupt trigger select |
| port_val | input | 1 | Level driven on the line while disabled |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| tx_out | output | 1 | Serial output line |
| buf_full | output | 1 | Buffer cannot accept another character |
| sh_empty | output | 1 | Shift register and buffer empty, nothing queued |
| brk_flag | output | 1 | Break pending or in progress |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
On every cycle the assertions check the following:
- an idle, enabled line sits at the level chosen by the polarity and encoder inputs;
- a full buffer stays full unless a character leaves;
- disabling clears the buffer, the break and the busy state within one cycle;
- the interrupt is never two cycles wide, and stays quiet in the reserved mode;
- the break flag only falls as the frame machine returns to idle.

The bench scenarios, compared against a behavioural model on every clock, are what show the rest:
- bit order and bit length;
- first-in-first-out order and dropped writes;
- which transfer or frame end raises each interrupt mode;
- the twelve-bit break length;
- the exact content of aborted and inverted frames.

// File: rtl/uart_tx_brk_pkg.sv
package uart_tx_brk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_BREAK,
        ST_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        IRQ_ON_LOAD  = 2'b00,
        IRQ_ON_DONE  = 2'b01,
        IRQ_ON_DRAIN = 2'b10,
        IRQ_NONE     = 2'b11
    } irq_mode_t;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !clr && wr_ptr == AW'(i)) mem[i] <= din;
        end
    end

    assign dout = mem[rd_ptr];
endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import uart_tx_brk_pkg::*;
#(
    parameter int W        = 8,
    parameter int OSR      = 16,
    parameter int BRK_BITS = 12,
    localparam int TW      = (OSR > 1) ? $clog2(OSR) : 1,
    localparam int BMAX    = (W > BRK_BITS) ? W : BRK_BITS,
    localparam int BW      = $clog2(BMAX + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         have_data,
    input  logic [W-1:0] din,
    input  logic         brk_pend,
    output logic         pop,
    output logic         frame_end,
    output logic         brk_frame,
    output logic         raw,
    output logic         idle
);
    localparam logic [TW-1:0] T_LAST   = TW'(OSR - 1);
    localparam logic [BW-1:0] D_LAST   = BW'(W - 1);
    localparam logic [BW-1:0] K_LAST   = BW'(BRK_BITS - 1);

    tx_state_t     state, nxt;
    logic [TW-1:0] tick_cnt;
    logic [BW-1:0] bit_cnt;
    logic [W-1:0]  shreg;
    logic          bit_last;
    logic          load;

    assign bit_last = tick && (tick_cnt == T_LAST);
    assign load     = en && (state == ST_IDLE) && (brk_pend || have_data);

    // next-state logic
    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (brk_pend || have_data) nxt = ST_START;
                ST_START: if (bit_last) nxt = brk_frame ? ST_BREAK : ST_DATA;
                ST_DATA:  if (bit_last && bit_cnt == D_LAST) nxt = ST_STOP;
                ST_BREAK: if (bit_last && bit_cnt == K_LAST) nxt = ST_STOP;
                ST_STOP:  if (bit_last) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt  <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            brk_frame <= 1'b0;
        end else begin
            if (!en || state == ST_IDLE) tick_cnt <= '0;
            else if (tick)               tick_cnt <= bit_last ? '0 : tick_cnt + 1'b1;

            if (load) begin
                brk_frame <= brk_pend;
                if (!brk_pend) shreg <= din;
            end

            if (state == ST_START && bit_last) begin
                bit_cnt <= '0;
            end else if ((state == ST_DATA || state == ST_BREAK) && bit_last) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (state == ST_DATA && bit_last) shreg <= shreg >> 1;
        end
    end

    // outputs
    always_comb begin
        raw       = 1'b1;
        pop       = 1'b0;
        frame_end = 1'b0;
        idle      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                idle = 1'b1;
                pop  = load && !brk_pend;
            end
            ST_START: raw = 1'b0;
            ST_DATA:  raw = shreg[0];
            ST_BREAK: raw = 1'b0;
            ST_STOP:  frame_end = en && bit_last;
            default:  raw = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import uart_tx_brk_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 4,
    parameter int OSR      = 16,
    parameter int BRK_BITS = 12,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              brk_set,
    input  logic              inv_sel,
    input  logic              enc_on,
    input  logic [1:0]        irq_mode,
    input  logic              port_val,
    input  logic              baud_tick,
    output logic              tx_out,
    output logic              buf_full,
    output logic              sh_empty,
    output logic              brk_flag,
    output logic              irq
);
    logic [CW-1:0]     count, cnt_nxt;
    logic [DATA_W-1:0] head;
    logic              push, fifo_pop, frame_end, brk_frame, raw, fsm_idle;
    logic              brk_nxt, irq_d, idle_lvl;

    assign buf_full = (count == CW'(DEPTH));
    assign push     = tx_en && wr_en && !buf_full;

    tx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!tx_en),
        .push  (push),
        .pop   (fifo_pop),
        .din   (wr_data),
        .dout  (head),
        .count (count)
    );

    tx_frame_fsm #(.W(DATA_W), .OSR(OSR), .BRK_BITS(BRK_BITS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (tx_en),
        .tick      (baud_tick),
        .have_data (count != '0),
        .din       (head),
        .brk_pend  (brk_flag),
        .pop       (fifo_pop),
        .frame_end (frame_end),
        .brk_frame (brk_frame),
        .raw       (raw),
        .idle      (fsm_idle)
    );

    assign cnt_nxt = count + CW'(push) - CW'(fifo_pop);

    always_comb begin
        if (!tx_en)                      brk_nxt = 1'b0;
        else if (brk_set)                brk_nxt = 1'b1;
        else if (frame_end && brk_frame) brk_nxt = 1'b0;
        else                             brk_nxt = brk_flag;
    end

    always_comb begin
        irq_d = 1'b0;
        unique case (irq_mode_t'(irq_mode))
            IRQ_ON_LOAD:  irq_d = fifo_pop;
            IRQ_ON_DONE:  irq_d = frame_end && (cnt_nxt == '0) && !brk_nxt;
            IRQ_ON_DRAIN: irq_d = fifo_pop && (cnt_nxt == '0);
            IRQ_NONE:     irq_d = 1'b0;
            default:      irq_d = 1'b0;
        endcase
        if (!tx_en) irq_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            brk_flag <= brk_nxt;
            irq      <= irq_d;
        end
    end

    assign sh_empty = fsm_idle && (count == '0) && !brk_flag;
    assign idle_lvl = enc_on ? inv_sel : !inv_sel;
    assign tx_out   = tx_en ? (raw ^ !idle_lvl) : port_val;
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       inv_sel,
    input logic       enc_on,
    input logic [1:0] irq_mode,
    input logic       tx_out,
    input logic       buf_full,
    input logic       sh_empty,
    input logic       brk_flag,
    input logic       irq,
    input logic       fsm_idle,
    input logic       fifo_pop
);
    p_full_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && buf_full && !fifo_pop) |=> buf_full);

    p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_empty && tx_en) |-> (tx_out == (enc_on ? inv_sel : !inv_sel)));

    p_irq_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_reserved_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode == 2'b11 && $past(irq_mode) == 2'b11) |-> !irq);

    p_abort_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (sh_empty && !buf_full && !brk_flag));

    p_break_ends_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(brk_flag) && $past(tx_en)) |-> fsm_idle);
endmodule

bind uart_tx_brk uart_tx_brk_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .inv_sel  (inv_sel),
    .enc_on   (enc_on),
    .irq_mode (irq_mode),
    .tx_out   (tx_out),
    .buf_full (buf_full),
    .sh_empty (sh_empty),
    .brk_flag (brk_flag),
    .irq      (irq),
    .fsm_idle (fsm_idle),
    .fifo_pop (fifo_pop)
);

// File: tb/uart_tx_brk_bench.sv
`timescale 1ns/1ps
module uart_tx_brk_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, wr_en = 1'b0, brk_set = 1'b0;
    logic [7:0] wr_data = '0;
    logic       inv_sel = 1'b0, enc_on = 1'b0, port_val = 1'b0, baud_tick = 1'b0;
    logic [1:0] irq_mode = 2'b00;
    logic       tx_out, buf_full, sh_empty, brk_flag, irq;

    int    errors = 0, checks = 0;
    int    tick_div = 1, tick_ph = 0;
    bit    finished = 1'b0;
    string ctx = "R2";

    always #2.5 clk = ~clk;

    uart_tx_brk u_uart_tx_brk (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
        .brk_set(brk_set), .inv_sel(inv_sel), .enc_on(enc_on), .irq_mode(irq_mode),
        .port_val(port_val), .baud_tick(baud_tick), .tx_out(tx_out),
        .buf_full(buf_full), .sh_empty(sh_empty), .brk_flag(brk_flag), .irq(irq)
    );

    // behavioural reference model
    logic [7:0] q[$];
    int         phase = 0;   // 0 idle, 1 start, 2 data, 3 break, 4 stop
    int         ticks = 0, bitn = 0;
    logic [7:0] cur = '0;
    bit         isbrk = 0, brkf = 0, irq_m = 0;

    always @(posedge clk) begin
        bit do_push, do_pop, fend;
        do_push = 0; do_pop = 0; fend = 0;
        if (!rst_n) begin
            q.delete(); phase = 0; ticks = 0; brkf = 0; irq_m = 0; isbrk = 0;
        end else if (!tx_en) begin
            q.delete(); phase = 0; ticks = 0; brkf = 0; irq_m = 0;
        end else begin
            do_push = wr_en && (q.size() < 4);
            if (phase == 0) begin
                ticks = 0;
                if (brkf) begin
                    phase = 1; isbrk = 1;
                end else if (q.size() > 0) begin
                    cur = q.pop_front(); do_pop = 1; isbrk = 0; phase = 1;
                end
            end else if (baud_tick) begin
                ticks++;
                if (ticks == 16) begin
                    ticks = 0;
                    case (phase)
                        1: begin phase = isbrk ? 3 : 2; bitn = 0; end
                        2: begin cur = cur >> 1; bitn++; if (bitn == 8) phase = 4; end
                        3: begin bitn++; if (bitn == 12) phase = 4; end
                        default: begin phase = 0; fend = 1; end
                    endcase
                end
            end
            if (do_push) q.push_back(wr_data);
            if (brk_set) brkf = 1;
            else if (fend && isbrk) brkf = 0;
            case (irq_mode)
                2'b00:   irq_m = do_pop;
                2'b10:   irq_m = do_pop && q.size() == 0;
                2'b01:   irq_m = fend && q.size() == 0 && !brkf;
                default: irq_m = 0;
            endcase
        end
    end

    function automatic logic exp_out();
        logic r, lvl;
        case (phase)
            0: r = 1'b1;
            2: r = cur[0];
            4: r = 1'b1;
            default: r = 1'b0;
        endcase
        lvl = enc_on ? inv_sel : !inv_sel;
        return tx_en ? (r ^ !lvl) : port_val;
    endfunction

    task automatic chk(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at %0t: actual=%b expected=%b", tag, what, $time, act, exp);
        end
    endtask

    string irq_tag;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            case (irq_mode)
                2'b00: irq_tag = "R4";
                2'b10: irq_tag = "R5";
                2'b01: irq_tag = "R6";
                default: irq_tag = "R7";
            endcase
            chk(ctx, "tx_out", tx_out, exp_out());
            chk("R1", "buf_full", buf_full, q.size() == 4);
            chk("R3", "sh_empty", sh_empty, phase == 0 && q.size() == 0 && !brkf);
            chk("R8", "brk_flag", brk_flag, brkf);
            chk(irq_tag, "irq", irq, irq_m);
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            wr_en = 1'b0;
            brk_set = 1'b0;
            tick_ph++;
            if (tick_ph >= tick_div) begin tick_ph = 0; baud_tick = 1'b1; end
            else baud_tick = 1'b0;
        end
    endtask

    task automatic put(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step(1);
    endtask

    task automatic drain();
        for (int i = 0; i < 8000 && !(sh_empty && !irq); i++) step(1);
        step(3);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        #1 rst_n = 1'b1;
        tx_en = 1'b1;
        step(1);
        #1;
        // R11: reset state
        chk("R11", "tx_out idle", tx_out, 1'b1);
        chk("R11", "sh_empty", sh_empty, 1'b1);
        chk("R11", "buf_full", buf_full, 1'b0);
        chk("R11", "irq", irq, 1'b0);
        chk("R11", "brk_flag", brk_flag, 1'b0);

        // R2 / R4: one frame, tick every cycle, load interrupt
        ctx = "R2"; irq_mode = 2'b00;
        put(8'hA5);
        drain();

        // R1 / R5: overfill the buffer, drain interrupt
        ctx = "R1"; irq_mode = 2'b10;
        put(8'h11); put(8'h22); put(8'h33); put(8'h44); put(8'h55); put(8'h66);
        drain();
        put(8'h81); step(2); put(8'h7E);
        drain();

        // R6: done interrupt, slower tick
        ctx = "R6"; irq_mode = 2'b01; tick_div = 3;
        put(8'hC3); put(8'h3C);
        drain();
        tick_div = 1;

        // R7: reserved mode
        ctx = "R7"; irq_mode = 2'b11;
        put(8'h0F);
        drain();

        // R8: break before queued data, no character consumed
        ctx = "R8"; irq_mode = 2'b00;
        brk_set = 1'b1; step(1);
        put(8'h96);
        drain();
        irq_mode = 2'b01;
        put(8'hF0); step(5);
        brk_set = 1'b1; step(1);
        drain();

        // R10: polarity with encoder on and off
        ctx = "R10"; irq_mode = 2'b00;
        enc_on = 1'b1; inv_sel = 1'b0; step(2);
        put(8'h5A);
        drain();
        enc_on = 1'b0; inv_sel = 1'b1; step(2);
        put(8'hE1);
        drain();
        inv_sel = 1'b0;

        // R9: abort mid-frame with data queued and break pending
        ctx = "R9";
        put(8'h12); put(8'h34); put(8'h56);
        step(40);
        brk_set = 1'b1; step(1);
        port_val = 1'b1; tx_en = 1'b0; step(2);
        put(8'h99);
        brk_set = 1'b1; step(1);
        port_val = 1'b0; step(3);
        tx_en = 1'b1; step(2);
        #1 chk("R9", "empty after abort", sh_empty, 1'b1);
        put(8'h3A);
        drain();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule